// File: doc/BRIEF.md
# Burst Address Generator with Selectable Beat Order

This block produces the address stream for a synchronous burst SRAM. A load cycle stores an external start address and presents it as the first beat. Each advance cycle after that presents the next beat of a four-beat burst. Only the two low address bits move. The upper bits keep their loaded value, so a burst never leaves its aligned four-word group.

The low bits follow one of two orders, picked by a mode input. The linear order adds the beat count to the start bits. The interleaved order XORs the beat count into the start bits. After the fourth beat the count wraps, so a fifth access lands on the loaded address again. A standby input freezes the block: while it is high, loads and advances have no effect and the output keeps its value.

The output is registered. The address for a load or an advance appears one clock after the edge that requests it. The mode input is sampled at every advance edge, so changing the mode in the middle of a burst alters only the beats that follow the change. The start address is not reloaded.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the output address, the stored start address and the beat count to zero. The first advance after reset therefore yields address 1.
- R2: Load: with `adv_ld` = 0 and `standby` = 0 at a clock edge, `burst_addr` equals the `ext_addr` of that edge one cycle later. The beat count restarts at 0.
- R3: Advance: with `adv_ld` = 1 and `standby` = 0 at a clock edge, the beat count steps by one and `burst_addr` shows the address of the new beat one cycle later. Bits above bit 1 stay equal to their loaded value.
- R4: Linear order (`order_sel` = 0): the low two bits equal (start low bits + beat count) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: Interleaved order (`order_sel` = 1): the low two bits equal start low bits XOR beat count. For example, start 01 gives 01, 00, 11, 10.
- R6: A burst is four beats long. After the third advance following a load, one more advance wraps the beat count to 0, and `burst_addr` equals the loaded address again.
- R7: With `standby` = 1 at a clock edge, both load and advance requests are ignored. `burst_addr`, the start address and the beat count keep their values. When `standby` returns to 0, the next advance continues from the held beat.
- R8: Changing `order_sel` in the middle of a burst does not reload the start address. The next advance computes its address from the same start and the next beat count, using the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_ld | input | 1 | 1 = advance to the next beat, 0 = load `ext_addr` |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| standby | input | 1 | 1 = hold all state and ignore requests |
| ext_addr | input | ADDR_W | Start address captured on a load |
| burst_addr | output | ADDR_W | Registered address of the current beat |

## Verification
The bench builds the block with a 12-bit address and a 2-bit beat count. At that size it can load every one of the four low-bit start values under both orders, with a distinctive upper-bit pattern. Each full burst plus its wrap beat is then compared against the arithmetic of R4 and R5. The same setting lets short directed scenarios reach the less common paths: standby in the middle of a burst, with both load and advance requested while frozen; an order flip halfway through a burst; and a reset that arrives during an active burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Beat ordering applied to the low address bits
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              inc,
   output logic [BEAT_W-1:0] beat,
   output logic [BEAT_W-1:0] beat_nxt
);

   localparam logic [BEAT_W-1:0] BEAT_ONE  = BEAT_W'(1);
   localparam logic [BEAT_W-1:0] BEAT_LAST = {BEAT_W{1'b1}};

   generate
      if (BEAT_W < 1) begin : g_bad_width
         $error("burst_beat_ctr: BEAT_W must be at least 1");
      end
   endgenerate

   logic [BEAT_W-1:0] beat_q;

   // Natural modulo wrap of the counter width returns to beat 0
   assign beat_nxt = beat_q + BEAT_ONE;
   assign beat     = beat_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_q <= '0;
      end else if (clr) begin
         beat_q <= '0;
      end else if (inc) begin
         beat_q <= beat_nxt;
      end
   end

   // R6
   beat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && !clr && beat_q == BEAT_LAST) |=> (beat_q == '0));

   // R2
   beat_clear_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (beat_q == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_lo,
   input  logic [BEAT_W-1:0] beat,
   input  burst_order_e      order,
   output logic [BEAT_W-1:0] beat_lo
);

   logic [BEAT_W-1:0] lin_lo;
   logic [BEAT_W-1:0] ilv_lo;

   // Linear order: modulo add within the beat field
   assign lin_lo = start_lo + beat;

   // Interleaved order: per-bit toggle of the start bits by the beat count
   genvar gi;
   generate
      for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv_bit
         assign ilv_lo[gi] = start_lo[gi] ^ beat[gi];
      end
   endgenerate

   always_comb begin
      unique case (order)
         ORD_INTERLEAVE: beat_lo = ilv_lo;
         default:        beat_lo = lin_lo;
      endcase
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_ld,
   input  logic              order_sel,
   input  logic              standby,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] burst_addr
);

   localparam int HI_W = ADDR_W - BEAT_W;

   generate
      if (ADDR_W <= BEAT_W) begin : g_bad_addr
         $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic              load_en;
   logic              step_en;
   logic [ADDR_W-1:0] start_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BEAT_W-1:0] beat;
   logic [BEAT_W-1:0] beat_nxt;
   logic [BEAT_W-1:0] nxt_lo;
   burst_order_e      order;

   assign load_en = !standby && !adv_ld;
   assign step_en = !standby &&  adv_ld;
   assign order   = burst_order_e'(order_sel);

   burst_beat_ctr #(
      .BEAT_W (BEAT_W)
   ) i_beat_ctr (
      .clk      (clk),
      .rst      (rst),
      .clr      (load_en),
      .inc      (step_en),
      .beat     (beat),
      .beat_nxt (beat_nxt)
   );

   burst_order_map #(
      .BEAT_W (BEAT_W)
   ) i_order_map (
      .start_lo (start_q[BEAT_W-1:0]),
      .beat     (beat_nxt),
      .order    (order),
      .beat_lo  (nxt_lo)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= '0;
         addr_q  <= '0;
      end else if (load_en) begin
         start_q <= ext_addr;
         addr_q  <= ext_addr;
      end else if (step_en) begin
         addr_q  <= {start_q[ADDR_W-1:BEAT_W], nxt_lo};
      end
   end

   assign burst_addr = addr_q;

   // Helper terms for the order checks, formed from separate registers
   logic [BEAT_W-1:0] lo_diff;
   logic [BEAT_W-1:0] lo_flip;
   assign lo_diff = addr_q[BEAT_W-1:0] - start_q[BEAT_W-1:0];
   assign lo_flip = addr_q[BEAT_W-1:0] ^ start_q[BEAT_W-1:0];

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      $past(rst) |-> (burst_addr == '0 && beat == '0));

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (burst_addr == $past(ext_addr)));

   // R3
   upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (burst_addr[ADDR_W-1:BEAT_W] == $past(burst_addr[ADDR_W-1:BEAT_W])));

   // R4
   linear_map_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && !order_sel) |=> (lo_diff == beat));

   // R5
   interleave_map_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && order_sel) |=> (lo_flip == beat));

   // R7
   standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
      standby |=> ($stable(burst_addr) && $stable(start_q) && $stable(beat)));

   // R8
   switch_keep_start_chk: assert property (@(posedge clk) disable iff (rst)
      step_en |=> $stable(start_q));

   localparam int UNUSED_HI = HI_W;

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 12;
   localparam int BW         = 2;
   localparam int WATCHDOG   = 5000;

   logic          clk = 1'b0;
   logic          rst;
   logic          adv_ld;
   logic          order_sel;
   logic          standby;
   logic [AW-1:0] ext_addr;
   logic [AW-1:0] burst_addr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_gen #(
      .ADDR_W (AW),
      .BEAT_W (BW)
   ) i_burst_addr_gen (
      .clk        (clk),
      .rst        (rst),
      .adv_ld     (adv_ld),
      .order_sel  (order_sel),
      .standby    (standby),
      .ext_addr   (ext_addr),
      .burst_addr (burst_addr)
   );

   // Expected address per requirement R4 / R5
   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] start,
                                              input int beat, input bit ilv);
      logic [1:0] s;
      logic [1:0] b;
      logic [1:0] lo;
      s  = start[1:0];
      b  = 2'(beat);
      lo = ilv ? (s ^ b) : 2'(s + b);
      return {start[AW-1:2], lo};
   endfunction

   task automatic check(input string req, input logic [AW-1:0] exp);
      total++;
      if (burst_addr !== exp) begin
         bad++;
         $display("FAIL %s: burst_addr=%h expected=%h", req, burst_addr, exp);
      end
   endtask

   // Drive inputs on the falling edge, let one rising edge pass, sample on the next falling edge
   task automatic cycle(input bit adv, input bit sel, input bit sby, input logic [AW-1:0] a);
      adv_ld    = adv;
      order_sel = sel;
      standby   = sby;
      ext_addr  = a;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      cycle(1'b0, 1'b1, 1'b0, 12'hFFF);
      cycle(1'b0, 1'b1, 1'b0, 12'hFFF);
      rst = 1'b0;
      check("R1 reset value", '0);
      cycle(1'b1, 1'b0, 1'b0, 12'h000);
      check("R1 first advance after reset", 12'h001);
   endtask

   task automatic t_load();
      cycle(1'b0, 1'b0, 1'b0, 12'hA5E);
      check("R2 load capture", 12'hA5E);
      cycle(1'b0, 1'b1, 1'b0, 12'h3C1);
      check("R2 reload restarts burst", 12'h3C1);
   endtask

   task automatic t_order(input bit ilv);
      for (int s = 0; s < 4; s++) begin
         logic [AW-1:0] st;
         st = {10'h2D3, 2'(s)};
         cycle(1'b0, ilv, 1'b0, st);
         check(ilv ? "R5 beat0" : "R4 beat0", st);
         for (int b = 1; b < 4; b++) begin
            cycle(1'b1, ilv, 1'b0, 12'h000);
            check(ilv ? "R5 interleaved beat / R3" : "R4 linear beat / R3",
                  exp_addr(st, b, ilv));
         end
         cycle(1'b1, ilv, 1'b0, 12'h000);
         check("R6 wrap to loaded address", st);
      end
   endtask

   task automatic t_standby();
      logic [AW-1:0] st;
      st = 12'h7B2;
      cycle(1'b0, 1'b0, 1'b0, st);
      cycle(1'b1, 1'b0, 1'b0, 12'h000);
      check("R7 pre-standby beat1", exp_addr(st, 1, 1'b0));
      cycle(1'b1, 1'b0, 1'b1, 12'h000);
      check("R7 advance ignored in standby", exp_addr(st, 1, 1'b0));
      cycle(1'b0, 1'b0, 1'b1, 12'h155);
      check("R7 load ignored in standby", exp_addr(st, 1, 1'b0));
      cycle(1'b1, 1'b0, 1'b1, 12'hEEE);
      check("R7 still held", exp_addr(st, 1, 1'b0));
      cycle(1'b1, 1'b0, 1'b0, 12'h000);
      check("R7 resume continues beat2", exp_addr(st, 2, 1'b0));
   endtask

   task automatic t_switch();
      logic [AW-1:0] st;
      st = 12'h4C1;
      cycle(1'b0, 1'b0, 1'b0, st);
      cycle(1'b1, 1'b0, 1'b0, 12'h000);
      check("R8 linear beat1", 12'h4C2);
      cycle(1'b1, 1'b1, 1'b0, 12'h000);
      check("R8 switched to interleaved beat2", 12'h4C3);
      cycle(1'b1, 1'b1, 1'b0, 12'h000);
      check("R8 interleaved beat3", 12'h4C2);
      cycle(1'b1, 1'b0, 1'b0, 12'h000);
      check("R8 back to linear wraps to start", 12'h4C1);
   endtask

   task automatic t_reset_mid();
      cycle(1'b0, 1'b0, 1'b0, 12'h9F6);
      cycle(1'b1, 1'b0, 1'b0, 12'h000);
      rst = 1'b1;
      cycle(1'b1, 1'b0, 1'b0, 12'h000);
      rst = 1'b0;
      check("R1 reset during burst", '0);
      cycle(1'b1, 1'b1, 1'b0, 12'h000);
      check("R1 beat restarts from zero", 12'h001);
   endtask

   initial begin
      for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: expired after %0d cycles, expected finish", WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst       = 1'b1;
      adv_ld    = 1'b0;
      order_sel = 1'b1;
      standby   = 1'b0;
      ext_addr  = '0;
      @(negedge clk);
      t_reset();
      t_load();
      t_order(1'b0);
      t_order(1'b1);
      t_standby();
      t_switch();
      t_reset_mid();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule